// File: doc/BRIEF.md
# Host Command/Response Mailbox Controller

This block is the host-facing mailbox of a communications coprocessor. It holds four 16-bit registers that the host can write as whole words or as single bytes, and reads back through a plain select/data read port. The registers carry a control word, a handshake and command word, and an 18-bit buffer address with flags spread over the last two registers.

Commands travel in both directions through the same registers. For input, the host asks for a slot, the block grants "ready for input", the host fills in the command, line and address fields and then clears the ready bit; that clearing write is what hands the command to the engine behind the mailbox, which sees a one-cycle valid pulse with the decoded code, line, direction and address. For output, the engine offers a posting; the block accepts it only while the register set is free, loads the fields and raises "ready for output", and the host frees the slot again by clearing that bit. Each ready bit drives its own registered interrupt request behind an enable, and an acknowledge returns a base vector for input or the base plus 4 for output.

Command execution behind the mailbox is outside this block.

Top module: `host_mailbox`

## Requirements
- R1: After reset all four registers read 0, both interrupt requests are low and the command-valid pulse is low.
- R2: A word write replaces the whole addressed register; a byte write (byte data on wrData[7:0]) to an odd address replaces only bits 15:8, to an even address only bits 7:0. Register i is at byte address 2i and read with rdSel = i; the new value reads back in the cycle after the write.
- R3: A write leaving register 0 bit 14 (master clear) set makes register 0 read exactly 16'h4000, zeroes registers 2, 4 and 6, drops both interrupt requests and stops running (register 0 bit 15 is the run bit).
- R4: While running, with register 0 bit 7 (request input) set and register 2 bit 7 (ready for output) clear, register 2 bit 4 (ready for input) is set in the cycle after; it is never granted while not running.
- R5: A host write to register 2 that takes ready-for-input from 1 to 0 while running gives cmdValid for the one following cycle with cmdCode = register 2 bits 1:0 (0 buffer-in, 1 control-in, 3 base-in), cmdRx = bit 2, cmdLine = bits 15:8 and cmdAddr = {register 6 bits 15:14, register 4}.
- R6: A posting is accepted (postAccept high in the request cycle) only while running, with both ready bits clear and no host write in that cycle; the cycle after, register 2 holds postLine in bits 15:8, bit 7 set, bit 2 = postRx, code 0; register 4 holds postAddr[15:0]; register 6 holds postAddr[17:16] in bits 15:14 and bit 12 set exactly when postRx is 1.
- R7: While ready-for-output is set, further postings are refused and ready-for-input is not granted; while ready-for-input is set, postings are refused. A host write clearing ready-for-output frees the slot.
- R8: irqIn rises when input enable (register 0 bit 0) and ready-for-input are both set and was not so before; irqOut likewise with output enable (bit 4) and ready-for-output. A request drops when its enable or ready bit drops. Both are registered and change with the register bits.
- R9: An acknowledge (ackReq, ackSel 0 input, 1 output) returns VEC_BASE or VEC_BASE+4 on ackVector when that request is pending, else 0, and clears only that request in the next cycle.
- R10: While not running, a host write clearing ready-for-input executes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 3 | Byte address of the write |
| wrByte | input | 1 | 1 = byte write, 0 = word write |
| wrData | input | 16 | Write data (byte data on bits 7:0) |
| rdSel | input | 2 | Register index to read |
| rdData | output | 16 | Read data of the selected register |
| postReq | input | 1 | Engine offers an output posting |
| postRx | input | 1 | Posting is receive type |
| postLine | input | 8 | Line number of the posting |
| postAddr | input | 18 | Buffer address of the posting |
| postAccept | output | 1 | Posting taken this cycle |
| cmdValid | output | 1 | One-cycle input command pulse |
| cmdCode | output | 2 | Input command code |
| cmdRx | output | 1 | Input command direction (1 = receive) |
| cmdLine | output | 8 | Input command line number |
| cmdAddr | output | 18 | Input command buffer address |
| irqIn | output | 1 | Input interrupt request |
| irqOut | output | 1 | Output interrupt request |
| ackReq | input | 1 | Interrupt acknowledge |
| ackSel | input | 1 | Acknowledged channel (0 input, 1 output) |
| ackVector | output | 9 | Vector returned on acknowledge |

## Verification
Register contents, the ready-for-input grant, posting contents and both interrupt requests all change at the clock edge that ends the write or posting cycle, so the bench drives at the falling edge and checks at the next falling edge. cmdValid is high only in the cycle after the clearing write and is checked there and again one cycle later to confirm it is a single pulse. postAccept and ackVector are combinational answers in the request cycle and are sampled a short delay after the inputs change, while the request they clear is checked at the following falling edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned LINE_W = 8;
  // register 0 bits
  localparam int unsigned B_RUN  = 15;
  localparam int unsigned B_MCLR = 14;
  localparam int unsigned B_RQI  = 7;
  localparam int unsigned B_IEO  = 4;
  localparam int unsigned B_IEI  = 0;
  // register 2 bits
  localparam int unsigned B_RDO  = 7;
  localparam int unsigned B_RDI  = 4;
  localparam int unsigned B_IOT  = 2;
  // register 6 bits
  localparam int unsigned B_EOM  = 12;

  typedef struct packed {
    logic wr0;
    logic wr2;
    logic wr4;
    logic wr6;
    logic mclr;
    logic post;
    logic setRdi;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      strb,
  input  logic [1:0]        wrSel,
  input  logic              wrOdd,
  input  logic              wrByte,
  input  logic [REG_W-1:0]  wrData,
  input  logic              postRx,
  input  logic [LINE_W-1:0] postLine,
  input  logic [ADDR_W-1:0] postAddr,
  input  logic [1:0]        rdSel,
  output logic [REG_W-1:0]  merged,
  output logic [REG_W-1:0]  reg0Q,
  output logic [REG_W-1:0]  reg2Q,
  output logic [REG_W-1:0]  reg4Q,
  output logic [REG_W-1:0]  reg6Q,
  output logic [REG_W-1:0]  rdData
);
  localparam int unsigned HI_W = ADDR_W - REG_W;

  logic [REG_W-1:0] regView [4];
  logic [REG_W-1:0] cur;
  logic [REG_W-1:0] postReg2;
  logic [REG_W-1:0] postReg6;

  assign regView[0] = reg0Q;
  assign regView[1] = reg2Q;
  assign regView[2] = reg4Q;
  assign regView[3] = reg6Q;

  assign cur    = regView[wrSel];
  assign rdData = regView[rdSel];

  always_comb begin
    if (!wrByte)
      merged = wrData;
    else if (wrOdd)
      merged = {wrData[7:0], cur[7:0]};
    else
      merged = {cur[15:8], wrData[7:0]};
  end

  always_comb begin
    postReg2 = '0;
    postReg2[REG_W-1 -: LINE_W] = postLine;
    postReg2[B_RDO] = 1'b1;
    postReg2[B_IOT] = postRx;
    postReg6 = '0;
    postReg6[REG_W-1 -: HI_W] = postAddr[ADDR_W-1:REG_W];
    postReg6[B_EOM] = postRx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reg0Q <= '0;
      reg2Q <= '0;
      reg4Q <= '0;
      reg6Q <= '0;
    end else if (strb.mclr) begin
      reg0Q <= REG_W'(1) << B_MCLR;
      reg2Q <= '0;
      reg4Q <= '0;
      reg6Q <= '0;
    end else begin
      if (strb.wr0) reg0Q <= merged;
      if (strb.post) begin
        reg2Q <= postReg2;
        reg4Q <= postAddr[REG_W-1:0];
        reg6Q <= postReg6;
      end else begin
        if (strb.wr2)
          reg2Q <= merged | (REG_W'(strb.setRdi) << B_RDI);
        else if (strb.setRdi)
          reg2Q[B_RDI] <= 1'b1;
        if (strb.wr4) reg4Q <= merged;
        if (strb.wr6) reg6Q <= merged;
      end
    end
  end
endmodule

// File: rtl/mbox_ctl.sv
module mbox_ctl
  import mbox_pkg::*;
#(
  parameter int unsigned VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'h160
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [REG_W-1:0] merged,
  input  logic [REG_W-1:0] reg0Q,
  input  logic [REG_W-1:0] reg2Q,
  input  logic             postReq,
  input  logic             ackReq,
  input  logic             ackSel,
  output mbox_strobe_t     strb,
  output logic             postAccept,
  output logic             cmdValid,
  output logic             irqIn,
  output logic             irqOut,
  output logic [VEC_W-1:0] ackVector
);
  localparam logic [VEC_W-1:0] VEC_OUT = VEC_BASE + VEC_W'(4);

  logic wr0, wr2, mclr, execIn, running;
  logic runH, rqiH, rdiH, rdoH, rdiNext, rdoNext, ieINext, ieONext;
  logic gateNow [2];
  logic gateNext [2];
  logic ackHit [2];
  logic irqQ [2];

  assign running = reg0Q[B_RUN];
  assign wr0  = wrEn && (wrSel == 2'd0);
  assign wr2  = wrEn && (wrSel == 2'd1);
  assign mclr = wr0 && merged[B_MCLR];

  // state as left by the host write alone
  assign runH = wr0 ? merged[B_RUN] : reg0Q[B_RUN];
  assign rqiH = wr0 ? merged[B_RQI] : reg0Q[B_RQI];
  assign rdiH = wr2 ? merged[B_RDI] : reg2Q[B_RDI];
  assign rdoH = wr2 ? merged[B_RDO] : reg2Q[B_RDO];

  assign execIn     = wr2 && running && reg2Q[B_RDI] && !merged[B_RDI];
  assign postAccept = postReq && !wrEn && running && !reg2Q[B_RDO] && !reg2Q[B_RDI];

  always_comb begin
    strb        = '0;
    strb.wr0    = wr0 && !mclr;
    strb.wr2    = wr2;
    strb.wr4    = wrEn && (wrSel == 2'd2);
    strb.wr6    = wrEn && (wrSel == 2'd3);
    strb.mclr   = mclr;
    strb.post   = postAccept;
    strb.setRdi = !mclr && runH && rqiH && !rdoH && !rdiH && !postAccept;
  end

  assign rdiNext = !mclr && (rdiH || strb.setRdi);
  assign rdoNext = !mclr && (rdoH || postAccept);
  assign ieINext = !mclr && (wr0 ? merged[B_IEI] : reg0Q[B_IEI]);
  assign ieONext = !mclr && (wr0 ? merged[B_IEO] : reg0Q[B_IEO]);

  assign gateNow[0]  = reg0Q[B_IEI] && reg2Q[B_RDI];
  assign gateNow[1]  = reg0Q[B_IEO] && reg2Q[B_RDO];
  assign gateNext[0] = ieINext && rdiNext;
  assign gateNext[1] = ieONext && rdoNext;

  for (genvar ch = 0; ch < 2; ch++) begin : g_irq
    assign ackHit[ch] = ackReq && (ackSel == 1'(ch)) && irqQ[ch];
    always_ff @(posedge clk) begin
      if (!rstN || !gateNext[ch])
        irqQ[ch] <= 1'b0;
      else if (!gateNow[ch])
        irqQ[ch] <= 1'b1;
      else if (ackHit[ch])
        irqQ[ch] <= 1'b0;
    end
  end

  assign irqIn  = irqQ[0];
  assign irqOut = irqQ[1];
  assign ackVector = ackHit[0] ? VEC_BASE : (ackHit[1] ? VEC_OUT : '0);

  always_ff @(posedge clk) begin
    if (!rstN) cmdValid <= 1'b0;
    else       cmdValid <= execIn;
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned VEC_W  = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'h160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic              wrByte,
  input  logic [REG_W-1:0]  wrData,
  input  logic [1:0]        rdSel,
  output logic [REG_W-1:0]  rdData,
  input  logic              postReq,
  input  logic              postRx,
  input  logic [LINE_W-1:0] postLine,
  input  logic [ADDR_W-1:0] postAddr,
  output logic              postAccept,
  output logic              cmdValid,
  output logic [1:0]        cmdCode,
  output logic              cmdRx,
  output logic [LINE_W-1:0] cmdLine,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              irqIn,
  output logic              irqOut,
  input  logic              ackReq,
  input  logic              ackSel,
  output logic [VEC_W-1:0]  ackVector
);
  localparam int unsigned HI_W = ADDR_W - REG_W;

  mbox_strobe_t     strb;
  logic [REG_W-1:0] merged, reg0Q, reg2Q, reg4Q, reg6Q;

  mbox_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrSel(wrAddr[2:1]), .wrOdd(wrAddr[0]), .wrByte(wrByte), .wrData(wrData),
    .postRx(postRx), .postLine(postLine), .postAddr(postAddr),
    .rdSel(rdSel), .merged(merged),
    .reg0Q(reg0Q), .reg2Q(reg2Q), .reg4Q(reg4Q), .reg6Q(reg6Q),
    .rdData(rdData)
  );

  mbox_ctl #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrAddr[2:1]),
    .merged(merged), .reg0Q(reg0Q), .reg2Q(reg2Q),
    .postReq(postReq), .ackReq(ackReq), .ackSel(ackSel),
    .strb(strb), .postAccept(postAccept), .cmdValid(cmdValid),
    .irqIn(irqIn), .irqOut(irqOut), .ackVector(ackVector)
  );

  assign cmdCode = reg2Q[1:0];
  assign cmdRx   = reg2Q[B_IOT];
  assign cmdLine = reg2Q[REG_W-1 -: LINE_W];
  assign cmdAddr = {reg6Q[REG_W-1 -: HI_W], reg4Q};
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [2:0]  wrAddr,
  input logic [15:0] reg0Q,
  input logic [15:0] reg2Q,
  input logic [15:0] reg4Q,
  input logic [15:0] reg6Q,
  input logic        postAccept,
  input logic        cmdValid,
  input logic        irqIn,
  input logic        irqOut
);
  p_mclr_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reg0Q[14]) |-> (reg0Q == 16'h4000) && (reg2Q == 16'h0) && (reg4Q == 16'h0)
                         && (reg6Q == 16'h0) && !irqIn && !irqOut);

  p_grant_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(reg2Q[4]) && !$past(wrEn)) |-> $past(reg0Q[15] && reg0Q[7] && !reg2Q[7]));

  p_cmd_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(wrEn) && ($past(wrAddr[2:1]) == 2'd1));

  p_post_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    postAccept |-> reg0Q[15] && !reg2Q[7] && !reg2Q[4]);

  p_post_sets_rdo_r6: assert property (@(posedge clk) disable iff (!rstN)
    postAccept |=> reg2Q[7]);

  p_irq_in_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqIn |-> reg0Q[0] && reg2Q[4]);

  p_irq_out_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> reg0Q[4] && reg2Q[7]);
endmodule

bind host_mailbox mbox_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .reg0Q(reg0Q), .reg2Q(reg2Q), .reg4Q(reg4Q), .reg6Q(reg6Q),
  .postAccept(postAccept), .cmdValid(cmdValid), .irqIn(irqIn), .irqOut(irqOut)
);

// File: tb/host_mailbox_test.sv
module host_mailbox_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic        wrByte = 1'b0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [15:0] rdData;
  logic        postReq = 1'b0;
  logic        postRx = 1'b0;
  logic [7:0]  postLine = '0;
  logic [17:0] postAddr = '0;
  logic        postAccept, cmdValid, cmdRx, irqIn, irqOut;
  logic [1:0]  cmdCode;
  logic [7:0]  cmdLine;
  logic [17:0] cmdAddr;
  logic        ackReq = 1'b0;
  logic        ackSel = 1'b0;
  logic [8:0]  ackVector;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  host_mailbox uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rdChk(input string tag, input logic [1:0] sel, input logic [15:0] exp);
    rdSel = sel;
    #1;
    check(tag, 32'(rdData), 32'(exp));
  endtask

  task automatic wr(input logic [2:0] a, input logic byteW, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrByte = byteW; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrByte = 1'b0;
  endtask

  task automatic tryPost(input logic rx, input logic [7:0] line, input logic [17:0] addr,
                         input logic expAcc, input string tag);
    @(negedge clk);
    postReq = 1'b1; postRx = rx; postLine = line; postAddr = addr;
    #1;
    check(tag, 32'(postAccept), 32'(expAcc));
    @(negedge clk);
    postReq = 1'b0;
  endtask

  task automatic ack(input logic sel, input logic [8:0] expVec, input string tag);
    @(negedge clk);
    ackReq = 1'b1; ackSel = sel;
    #1;
    check(tag, 32'(ackVector), 32'(expVec));
    @(negedge clk);
    ackReq = 1'b0;
  endtask

  task automatic t_reset();
    rdChk("R1 reg0", 2'd0, 16'h0);
    rdChk("R1 reg2", 2'd1, 16'h0);
    rdChk("R1 reg4", 2'd2, 16'h0);
    rdChk("R1 reg6", 2'd3, 16'h0);
    check("R1 irqIn", 32'(irqIn), 0);
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 cmdValid", 32'(cmdValid), 0);
  endtask

  task automatic t_bytes();
    wr(3'd4, 1'b0, 16'h1234);
    rdChk("R2 word", 2'd2, 16'h1234);
    wr(3'd5, 1'b1, 16'h00AB);
    rdChk("R2 odd byte", 2'd2, 16'hAB34);
    wr(3'd4, 1'b1, 16'h00CD);
    rdChk("R2 even byte", 2'd2, 16'hABCD);
  endtask

  task automatic t_grant();
    wr(3'd0, 1'b0, 16'h0080);
    rdChk("R4 no grant idle", 2'd1, 16'h0000);
    wr(3'd0, 1'b0, 16'h8081);
    rdChk("R4 grant", 2'd1, 16'h0010);
    check("R8 irqIn rises", 32'(irqIn), 1);
    check("R8 irqOut low", 32'(irqOut), 0);
  endtask

  task automatic t_ackIn();
    ack(1'b0, 9'h160, "R9 input vector");
    check("R9 irqIn cleared", 32'(irqIn), 0);
    ack(1'b1, 9'h000, "R9 output not pending");
    tryPost(1'b0, 8'd0, 18'h0, 1'b0, "R7 post blocked by rdi");
  endtask

  task automatic t_exec();
    wr(3'd6, 1'b0, 16'h8000);
    wr(3'd4, 1'b0, 16'h2468);
    wr(3'd2, 1'b0, 16'h0303);
    check("R5 valid", 32'(cmdValid), 1);
    check("R5 code base-in", 32'(cmdCode), 3);
    check("R5 rx", 32'(cmdRx), 0);
    check("R5 line", 32'(cmdLine), 3);
    check("R5 addr", 32'(cmdAddr), 32'h22468);
    rdChk("R4 regrant", 2'd1, 16'h0313);
    @(negedge clk);
    check("R5 single pulse", 32'(cmdValid), 0);
    wr(3'd2, 1'b0, 16'h0104);
    check("R5 rx buffer-in valid", 32'(cmdValid), 1);
    check("R5 rx buffer-in code", 32'(cmdCode), 0);
    check("R5 rx buffer-in dir", 32'(cmdRx), 1);
    check("R5 rx buffer-in line", 32'(cmdLine), 1);
  endtask

  task automatic t_post();
    wr(3'd0, 1'b0, 16'h8011);
    rdChk("R4 rdi held", 2'd1, 16'h0114);
    wr(3'd2, 1'b0, 16'h0000);
    check("R5 buffer-in exec", 32'(cmdValid), 1);
    rdChk("R4 no regrant without rqi", 2'd1, 16'h0000);
    tryPost(1'b1, 8'd5, 18'h3ABCD, 1'b1, "R6 accept rx");
    rdChk("R6 reg2", 2'd1, 16'h0584);
    rdChk("R6 reg4", 2'd2, 16'hABCD);
    rdChk("R6 reg6 eom", 2'd3, 16'hD000);
    check("R8 irqOut rises", 32'(irqOut), 1);
    tryPost(1'b0, 8'd1, 18'h1, 1'b0, "R7 post blocked by rdo");
    wr(3'd0, 1'b0, 16'h8091);
    rdChk("R7 no grant while rdo", 2'd1, 16'h0584);
    ack(1'b1, 9'h164, "R9 output vector");
    check("R9 irqOut cleared", 32'(irqOut), 0);
    wr(3'd2, 1'b0, 16'h0000);
    check("R5 no exec on rdo clear", 32'(cmdValid), 0);
    rdChk("R7 grant after rdo freed", 2'd1, 16'h0010);
    check("R8 irqIn on new grant", 32'(irqIn), 1);
    tryPost(1'b0, 8'd1, 18'h1, 1'b0, "R7 post blocked by new rdi");
    wr(3'd0, 1'b0, 16'h8010);
    check("R8 irqIn drops with enable", 32'(irqIn), 0);
    wr(3'd2, 1'b0, 16'h0000);
    check("R5 exec", 32'(cmdValid), 1);
    tryPost(1'b0, 8'd2, 18'h10020, 1'b1, "R6 accept tx");
    rdChk("R6 tx reg2", 2'd1, 16'h0280);
    rdChk("R6 tx reg4", 2'd2, 16'h0020);
    rdChk("R6 tx reg6 no eom", 2'd3, 16'h4000);
    check("R8 irqOut tx", 32'(irqOut), 1);
  endtask

  task automatic t_idle();
    wr(3'd0, 1'b0, 16'h0000);
    check("R8 irqOut drops with enable", 32'(irqOut), 0);
    wr(3'd2, 1'b0, 16'h0010);
    wr(3'd2, 1'b0, 16'h0000);
    check("R10 no exec idle", 32'(cmdValid), 0);
    rdChk("R10 reg2", 2'd1, 16'h0000);
    tryPost(1'b0, 8'd1, 18'h1, 1'b0, "R6 refused idle");
  endtask

  task automatic t_mclr();
    wr(3'd0, 1'b0, 16'h8081);
    check("R8 irqIn before clear", 32'(irqIn), 1);
    wr(3'd6, 1'b0, 16'h1234);
    wr(3'd1, 1'b1, 16'h0040);
    rdChk("R3 reg0", 2'd0, 16'h4000);
    rdChk("R3 reg2", 2'd1, 16'h0000);
    rdChk("R3 reg4", 2'd2, 16'h0000);
    rdChk("R3 reg6", 2'd3, 16'h0000);
    check("R3 irqIn", 32'(irqIn), 0);
    check("R3 irqOut", 32'(irqOut), 0);
    tryPost(1'b0, 8'd1, 18'h1, 1'b0, "R3 stopped");
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_grant();
    t_ackIn();
    t_exec();
    t_post();
    t_idle();
    t_mclr();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule